// File: doc/BRIEF.md
# Fixed-Priority DMA Request Arbiter

This block decides which of four DMA channels may use a bus that it shares with a CPU. Each channel holds one pending bit. A trigger on the channel sets that bit, and only while the channel is enabled. Triggers are captured on the falling edge of the bus clock, so every trigger that arrives in the same falling-to-falling window becomes pending on the same rising edge.

When the CPU is not asking for the bus and at least one enabled channel is pending, the arbiter hands the bus to the lowest-numbered pending channel. On that same edge it clears the channel's pending bit, and it holds the channel index steady while the transfer runs. Address generation and transfer counting are done by an external sequencer. When the sequencer reports that its single transfer is complete, the bus goes back to the CPU. No further channel is granted until the CPU has completed one bus access.

All pins are plain control and status signals. No data flows through this block, so it has no valid/ready interface.

Top module: `dma_prio_arbiter`

## Requirements
- R1: When several enabled channels are pending at a grant decision, the lowest channel index wins (channel 0 over 1, 1 over 2, 2 over 3).
- R2: A trigger is captured at the falling clock edge. The channel becomes pending at the next rising edge, and the grant (`dma_own_o` high) can appear at the rising edge after that. Triggers captured in the same window become pending together.
- R3: A channel holds a single pending bit. Extra triggers that arrive while it is pending produce no additional grant.
- R4: A channel's pending bit clears on the edge that grants it. A trigger captured after that edge makes the channel pending again, and it is served by a later grant.
- R5: Each grant covers exactly one transfer. `dma_own_o` falls on the edge where `xfer_done_i` is sampled high.
- R6: A channel whose enable input is low never becomes pending and is never granted.
- R7: After a transfer, no channel is granted until `cpu_done_i` has been sampled high. The earliest next grant comes one edge after that.
- R8: `grant_ch_o` stays constant for as long as `dma_own_o` is high.
- R9: While the bus is free, no grant is issued in any cycle in which `cpu_req_i` is high.
- R10: After reset, nothing is pending, `dma_own_o` is 0 and `grant_ch_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | NCH | Per-channel transfer trigger, captured at the falling edge |
| en_i | input | NCH | Per-channel enable |
| cpu_req_i | input | 1 | CPU wants the bus; blocks new grants |
| cpu_done_i | input | 1 | CPU completed one bus access |
| xfer_done_i | input | 1 | Sequencer finished the current transfer |
| grant_ch_o | output | CHW | Index of the granted channel |
| dma_own_o | output | 1 | 1 = DMA owns the bus, 0 = CPU owns it |

## Verification
The embedded assertions check the following on every clock:
- a captured trigger always becomes pending (R2);
- a grant clears the pending bit (R4);
- each grant picks the lowest pending enabled channel (R1, R6);
- ownership drops on the edge that sees transfer-done (R5);
- no grant is issued during the CPU gap or while the CPU is requesting (R7, R9);
- the granted index does not move while DMA owns the bus (R8).

Some properties cover several cycles and several triggers, so only the bench scenarios can show them:
- that repeated triggers are absorbed into one grant (R3);
- that a retrigger after the grant produces a second grant (R4);
- the exact grant order for every trigger mask and every enable mask.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } bus_state_e;
endpackage

// File: rtl/dma_req_flags.sv
module dma_req_flags #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] trig_i,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] flag_o
);
  logic [NCH-1:0] smp_q;
  logic [NCH-1:0] flag_q;

  // capture window closes at the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= trig_i & en_i;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= (flag_q[g] & ~clr_i[g]) | smp_q[g];
    end

    a_r2_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
      smp_q[g] |=> flag_q[g]);
    a_r4_grant_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !smp_q[g]) |=> !flag_q[g]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req_i,
  output logic           hit_o,
  output logic [CHW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CHW'(i);
    end
  end

  assign hit_o = |req_i;
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_i,
  input  logic [CHW-1:0] win_i,
  input  logic           cpu_req_i,
  input  logic           cpu_done_i,
  input  logic           xfer_done_i,
  output logic [NCH-1:0] clr_o,
  output logic [CHW-1:0] ch_o,
  output logic           own_o
);
  bus_state_e st_q, st_d;
  logic [CHW-1:0] ch_q;
  logic go;

  assign go = (st_q == ST_FREE) && any_i && !cpu_req_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FREE: if (go)          st_d = ST_XFER;
      ST_XFER: if (xfer_done_i) st_d = ST_GAP;
      ST_GAP:  if (cpu_done_i)  st_d = ST_FREE;
      default:                  st_d = ST_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FREE;
      ch_q <= '0;
    end else begin
      st_q <= st_d;
      if (go) ch_q <= win_i;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_clr
    assign clr_o[g] = go && (win_i == CHW'(g));
  end

  assign ch_o  = ch_q;
  assign own_o = (st_q == ST_XFER);

  a_r5_one_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (own_o && xfer_done_i) |=> !own_o);
  a_r7_cpu_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |=> !own_o);
  a_r8_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (own_o && !xfer_done_i) |=> (own_o && $stable(ch_o)));
  a_r9_cpu_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FREE) && cpu_req_i) |=> !own_o);
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] trig_i,
  input  logic [NCH-1:0] en_i,
  input  logic           cpu_req_i,
  input  logic           cpu_done_i,
  input  logic           xfer_done_i,
  output logic [CHW-1:0] grant_ch_o,
  output logic           dma_own_o
);
  logic [NCH-1:0] flag, pend, clr;
  logic           hit;
  logic [CHW-1:0] win;

  dma_req_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .en_i(en_i),
    .clr_i(clr), .flag_o(flag)
  );

  assign pend = flag & en_i;

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .req_i(pend), .hit_o(hit), .idx_o(win)
  );

  dma_bus_fsm #(.NCH(NCH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .any_i(hit), .win_i(win),
    .cpu_req_i(cpu_req_i), .cpu_done_i(cpu_done_i), .xfer_done_i(xfer_done_i),
    .clr_o(clr), .ch_o(grant_ch_o), .own_o(dma_own_o)
  );

  // channels strictly below the granted one, used by the priority check
  logic [NCH-1:0] below_mask;
  assign below_mask = (NCH'(1) << grant_ch_o) - NCH'(1);

  a_r1_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_own_o) |-> ((($past(pend) & below_mask) == '0)
                          && ((($past(pend) >> grant_ch_o) & NCH'(1)) != '0)));
  a_r6_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_own_o) |-> ((($past(en_i) >> grant_ch_o) & NCH'(1)) != '0));
  a_r10_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> (!dma_own_o && grant_ch_o == '0));
endmodule

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;
  localparam int NCH = 4;
  localparam int CHW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] trig = '0;
  logic [NCH-1:0] en = '1;
  logic cpu_req = 1'b0, cpu_done = 1'b0, xfer_done = 1'b0;
  logic [CHW-1:0] grant_ch;
  logic own;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  dma_prio_arbiter #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .en_i(en),
    .cpu_req_i(cpu_req), .cpu_done_i(cpu_done), .xfer_done_i(xfer_done),
    .grant_ch_o(grant_ch), .dma_own_o(own)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_trig(input logic [NCH-1:0] m);
    trig = m;
    tick();
    trig = '0;
  endtask

  task automatic wait_own(input string req, input int exp_ch);
    for (int k = 0; k < 8 && !own; k++) tick();
    chk(own, req, own, 1);
    chk(grant_ch == CHW'(exp_ch), req, grant_ch, exp_ch);
  endtask

  // end the transfer, confirm the CPU gap, then complete one CPU access
  task automatic finish_xfer();
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    chk(!own, "R5", own, 0);
    tick();
    tick();
    chk(!own, "R7", own, 0);
    cpu_req = 1'b1;
    cpu_done = 1'b1;
    tick();
    cpu_done = 1'b0;
    cpu_req = 1'b0;
  endtask

  task automatic quiet(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      tick();
      chk(!own, req, own, 0);
    end
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick();
    tick();
    chk(!own, "R10", own, 0);
    chk(grant_ch == '0, "R10", grant_ch, 0);
    rst_n = 1'b1;
    quiet("R10", 3);

    // R2: trigger in one window, pending at next rise, grant one edge later
    trig = 4'b0100;
    tick();
    trig = '0;
    chk(!own, "R2", own, 0);
    tick();
    chk(own, "R2", own, 1);
    chk(grant_ch == 2, "R2", grant_ch, 2);
    finish_xfer();
    quiet("R2", 3);

    // R1: every trigger mask, all raised in the same window
    for (int m = 1; m < 16; m++) begin
      pulse_trig(NCH'(m));
      for (int c = 0; c < NCH; c++) begin
        if (m[c]) begin
          wait_own("R1", c);
          finish_xfer();
        end
      end
      quiet("R1", 4);
    end

    // R6: every enable mask with all channels triggered
    for (int e = 0; e < 16; e++) begin
      en = NCH'(e);
      pulse_trig('1);
      for (int c = 0; c < NCH; c++) begin
        if (e[c]) begin
          wait_own("R6", c);
          finish_xfer();
        end
      end
      quiet("R6", 4);
    end
    en = '1;

    // R9 and R3: CPU holds the bus while channel 1 is retriggered three times
    cpu_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      pulse_trig(4'b0010);
      tick();
      chk(!own, "R9", own, 0);
    end
    quiet("R9", 3);
    cpu_req = 1'b0;
    wait_own("R3", 1);
    finish_xfer();
    quiet("R3", 6);

    // R8: index holds while a higher-priority channel arrives mid-transfer
    pulse_trig(4'b1000);
    wait_own("R8", 3);
    pulse_trig(4'b0001);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(own && grant_ch == 3, "R8", grant_ch, 3);
    end
    finish_xfer();
    wait_own("R8", 0);
    finish_xfer();
    quiet("R8", 3);

    // R4: pending clears at the grant, so a retrigger during service counts
    pulse_trig(4'b0010);
    wait_own("R4", 1);
    pulse_trig(4'b0010);
    finish_xfer();
    wait_own("R4", 1);
    finish_xfer();
    quiet("R4", 4);

    // R7: nothing is granted until the CPU access completes
    pulse_trig(4'b0101);
    wait_own("R7", 0);
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    quiet("R7", 6);
    cpu_done = 1'b1;
    tick();
    cpu_done = 1'b0;
    chk(!own, "R7", own, 0);
    tick();
    chk(own && grant_ch == 2, "R7", grant_ch, 2);
    finish_xfer();
    quiet("R7", 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule